// File: doc/BRIEF.md
# Packed-BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date in packed BCD. It holds seconds, minutes, hours, weekday, day of month, month and a two-digit year that stands for 2000 to 2099. An internal prescaler divides the system clock by `TICK_DIV` and makes one advance per second. Each advance ripples carries through the fields. Day-of-month wrap follows the length of the month, including leap-year February.

The hours byte chooses its own format. With bit 6 clear it counts 00 to 23. With bit 6 set it counts 01 to 12, and bit 5 marks PM. In that mode midnight reads 12 AM and noon reads 12 PM.

A host loads fields one byte at a time through a write port. Address 7 is a control byte whose bit 7 stops the prescaler and the count. Writing seconds restarts the prescaler, so the first full second begins at that write.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00 in 24-hour format, weekday 0x01, day 0x01, month 0x01, year 0x00, and halted is 0.
- R2: While running, seconds advance by one BCD step every `TICK_DIV` clocks. Seconds wrap 0x59 to 0x00 and carry into minutes. Minutes wrap 0x59 to 0x00 and carry into hours.
- R3: With hours bit 6 clear, the hours byte counts 0x00 to 0x23. It wraps 0x23 to 0x00 and carries one day. Bit 6 changes only by a host write.
- R4: With hours bit 6 set, bits 4..0 hold 01 to 12 in BCD and bit 5 is PM. The hour steps 12 to 01 with PM kept. It steps 11 to 12 with PM toggled. Only 11 PM to 12 AM carries one day; PM changes on no other step.
- R5: On each day carry, the weekday steps 1 to 7 and wraps 7 to 1.
- R6: On each day carry, the day of month wraps to 0x01 and carries into the month after its last day. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11. It is 0x28 or 0x29 for month 0x02, and 0x31 for every other month.
- R7: February has 29 days exactly when the year is divisible by 4. This includes year 00.
- R8: The month wraps 0x12 to 0x01 and carries into the year. The year wraps 0x99 to 0x00.
- R9: When `wr_en` is high, the register at `wr_addr` takes `wr_data` on the clock edge. The addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year and 7 control. A second that would elapse in a write cycle is dropped.
- R10: Writing control bit 7 as 1 freezes the prescaler and all time fields, and `halted_o` reads 1. Writing it as 0 resumes the count from the held prescaler value.
- R11: A write to seconds clears the prescaler. The next advance then comes exactly `TICK_DIV` clocks after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Value to write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format bit 6 and PM bit 5 |
| wday_o | output | 8 | Weekday 1 to 7 |
| mday_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00 to 99, BCD |
| halted_o | output | 1 | Count is stopped |

## Verification
The bench builds the block with `TICK_DIV` set to 4, so a second is four clocks. At that rate a minute carry shows up within a few hundred cycles of free running. Host writes place the count just before each year, month, leap-February and 12-hour boundary, and the crossing follows a few clocks later. A behavioural model keeps the hour as 0 to 23 and derives the 12-hour encoding from it. The model is compared with every output on every clock.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       halted_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] presc_q;
  logic [7:0] sec_q, min_q, hr_q, wd_q, md_q, mo_q, yr_q;
  logic halt_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  logic tick, sec_wrap, min_wrap, leap, day_end;
  logic [7:0] hr_next, last_day, h12_inc, h24_inc;
  logic hr_carry;

  assign tick     = !halt_q && (presc_q == LAST);
  assign sec_wrap = (sec_q == 8'h59);
  assign min_wrap = (min_q == 8'h59);
  assign leap     = yr_q[4] ? (yr_q[3:0] == 4'h2 || yr_q[3:0] == 4'h6)
                            : (yr_q[3:0] == 4'h0 || yr_q[3:0] == 4'h4 || yr_q[3:0] == 4'h8);
  assign h12_inc  = bcd_inc({3'b000, hr_q[4:0]});
  assign h24_inc  = bcd_inc({2'b00, hr_q[5:0]});
  assign day_end  = sec_wrap && min_wrap && hr_carry;

  always_comb begin
    hr_carry = 1'b0;
    if (hr_q[6]) begin
      if (hr_q[4:0] == 5'h12)      hr_next = {2'b01, hr_q[5], 5'h01};
      else if (hr_q[4:0] == 5'h11) begin
        hr_next  = {2'b01, ~hr_q[5], 5'h12};
        hr_carry = hr_q[5];
      end
      else                         hr_next = {2'b01, hr_q[5], h12_inc[4:0]};
    end else begin
      if (hr_q[5:0] == 6'h23) begin
        hr_next  = 8'h00;
        hr_carry = 1'b1;
      end
      else hr_next = {2'b00, h24_inc[5:0]};
    end
  end

  always_comb begin
    case (mo_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      wd_q <= 8'h01; md_q <= 8'h01; mo_q <= 8'h01; yr_q <= 8'h00;
      halt_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 3'd0) presc_q <= '0;
      else if (!halt_q)             presc_q <= tick ? '0 : presc_q + 1'b1;

      if (wr_en) begin
        case (wr_addr)
          3'd0: sec_q  <= wr_data;
          3'd1: min_q  <= wr_data;
          3'd2: hr_q   <= wr_data;
          3'd3: wd_q   <= wr_data;
          3'd4: md_q   <= wr_data;
          3'd5: mo_q   <= wr_data;
          3'd6: yr_q   <= wr_data;
          default: halt_q <= wr_data[7];
        endcase
      end else if (tick) begin
        sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
        if (sec_wrap) begin
          min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
          if (min_wrap) hr_q <= hr_next;
        end
        if (day_end) begin
          wd_q <= (wd_q == 8'h07) ? 8'h01 : wd_q + 8'd1;
          md_q <= (md_q == last_day) ? 8'h01 : bcd_inc(md_q);
          if (md_q == last_day) begin
            mo_q <= (mo_q == 8'h12) ? 8'h01 : bcd_inc(mo_q);
            if (mo_q == 8'h12) yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
          end
        end
      end
    end
  end

  assign sec_o = sec_q;   assign min_o = min_q;   assign hour_o = hr_q;
  assign wday_o = wd_q;   assign mday_o = md_q;   assign month_o = mo_q;
  assign year_o = yr_q;   assign halted_o = halt_q;

  assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sec_q != 8'h59) |=> $stable(min_q));
  assert_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hr_q[6]));
  assert_pm_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && hr_q[6] && hr_q[4:0] != 5'h11) |=> $stable(hr_q[5]));
  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_en) |=> $stable({sec_q, min_q, hr_q, wd_q, md_q, mo_q, yr_q, presc_q}));
  assert_presc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (presc_q == '0));
endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;
  logic halted_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .month_o(month_o), .year_o(year_o), .halted_o(halted_o));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // behavioural reference: binary fields, hour kept 0..23
  int m_s, m_m, m_h, m_wd, m_md, m_mo, m_yr, m_pre;
  bit m_12, m_halt;

  function automatic logic [7:0] exp_hour();
    int h12;
    if (!m_12) return to_bcd(m_h);
    h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
    return {1'b0, 1'b1, (m_h >= 12) ? 1'b1 : 1'b0, to_bcd(h12)[4:0]};
  endfunction

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_s = 0; m_m = 0; m_h = 0; m_wd = 1; m_md = 1; m_mo = 1; m_yr = 0;
      m_pre = 0; m_12 = 0; m_halt = 0;
    end else begin
      tk = 0;
      if (!m_halt) begin
        if (m_pre == DIV - 1) begin m_pre = 0; tk = 1; end
        else m_pre++;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_s = from_bcd(wr_data); m_pre = 0; end
          3'd1: m_m = from_bcd(wr_data);
          3'd2: begin
            if (wr_data[6]) begin
              m_12 = 1;
              m_h = (from_bcd({3'b000, wr_data[4:0]}) % 12) + (wr_data[5] ? 12 : 0);
            end else begin
              m_12 = 0; m_h = from_bcd({2'b00, wr_data[5:0]});
            end
          end
          3'd3: m_wd = from_bcd(wr_data);
          3'd4: m_md = from_bcd(wr_data);
          3'd5: m_mo = from_bcd(wr_data);
          3'd6: m_yr = from_bcd(wr_data);
          default: m_halt = wr_data[7];
        endcase
      end else if (tk) begin
        m_s++;
        if (m_s == 60) begin
          m_s = 0; m_m++;
          if (m_m == 60) begin
            m_m = 0; m_h++;
            if (m_h == 24) begin
              m_h = 0;
              m_wd = (m_wd == 7) ? 1 : m_wd + 1;
              m_md++;
              if (m_md > days_in(m_mo, m_yr)) begin
                m_md = 1; m_mo++;
                if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
              end
            end
          end
        end
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 seconds", sec_o, to_bcd(m_s));
      check("R2 minutes", min_o, to_bcd(m_m));
      check("R4 hours", hour_o, exp_hour());
      check("R5 weekday", wday_o, to_bcd(m_wd));
      check("R6 day", mday_o, to_bcd(m_md));
      check("R8 month", month_o, to_bcd(m_mo));
      check("R8 year", year_o, to_bcd(m_yr));
      check("R10 halted", {7'd0, halted_o}, {7'd0, m_halt});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] yr, mo, md, wd, hr, mi, se);
    logic [7:0] vals [7];
    vals = '{yr, mo, md, wd, hr, mi, se};
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'(6 - i); wr_data = vals[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic one_tick();
    repeat (DIV) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sec", sec_o, 8'h00); check("R1 hour", hour_o, 8'h00);
    check("R1 wday", wday_o, 8'h01); check("R1 mday", mday_o, 8'h01);
    check("R1 month", month_o, 8'h01); check("R1 year", year_o, 8'h00);

    repeat (260) @(negedge clk);
    check("R2 minute carry", min_o, 8'h01);

    set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59); one_tick();
    check("R3 hour wrap", hour_o, 8'h00); check("R5 weekday wrap", wday_o, 8'h01);
    check("R8 month wrap", month_o, 8'h01); check("R8 year wrap", year_o, 8'h00);

    set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); one_tick();
    check("R7 leap feb29", mday_o, 8'h29);
    set_all(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59); one_tick();
    check("R6 feb29 end", month_o, 8'h03);
    set_all(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); one_tick();
    check("R6 feb28 end", mday_o, 8'h01); check("R6 feb28 month", month_o, 8'h03);
    set_all(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); one_tick();
    check("R7 year00 leap", mday_o, 8'h29);
    set_all(8'h10, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); one_tick();
    check("R6 april end", month_o, 8'h05);
    set_all(8'h10, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); one_tick();
    check("R6 jan31 reach", mday_o, 8'h31);

    set_all(8'h10, 8'h05, 8'h15, 8'h02, 8'h51, 8'h59, 8'h59); one_tick();
    check("R4 11AM to 12PM", hour_o, 8'h72); check("R4 no carry", mday_o, 8'h15);
    set_all(8'h10, 8'h05, 8'h15, 8'h02, 8'h72, 8'h59, 8'h59); one_tick();
    check("R4 12PM to 1PM", hour_o, 8'h61);
    set_all(8'h10, 8'h05, 8'h15, 8'h02, 8'h71, 8'h59, 8'h59); one_tick();
    check("R4 11PM to 12AM", hour_o, 8'h52); check("R4 day carry", mday_o, 8'h16);
    set_all(8'h10, 8'h05, 8'h15, 8'h02, 8'h52, 8'h59, 8'h59); one_tick();
    check("R4 12AM to 1AM", hour_o, 8'h41);

    wr(3'd1, 8'h33);
    check("R9 minute load", min_o, 8'h33);
    wr(3'd0, 8'h10);
    repeat (DIV - 1) @(negedge clk);
    check("R11 not yet", sec_o, 8'h10);
    @(negedge clk);
    check("R11 first tick", sec_o, 8'h11);

    wr(3'd0, 8'h20);
    wr(3'd7, 8'h80);
    repeat (40) @(negedge clk);
    check("R10 frozen", sec_o, 8'h20); check("R10 flag", {7'd0, halted_o}, 8'h01);
    wr(3'd7, 8'h00);
    repeat (DIV + 1) @(negedge clk);
    check("R10 resumed", sec_o, 8'h21);

    repeat (50) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule